// File: doc/BRIEF.md
# Three-Channel Ramp DAC Conversion Sequencer

This block is the digital side of a three-channel ramp-type digital-to-analog converter. An external ramp generator produces a rising voltage in step with one shared count. Each channel holds a 12-bit code. When the shared count reaches a channel's code, that channel gets a one-clock sample strobe, and its track-and-hold amplifier captures the ramp voltage at that moment. One sweep covers all 4096 count values. At a 4.125 MHz count clock this gives an update rate of about 1 kilosample per second on all three outputs at once.

A conversion request is a single valid/ready transfer that carries all three codes. The transfer completes on a clock edge where `req_valid` and `req_ready` are both high. At that edge the codes are converted to Gray code and stored. In the next cycle `ramp_rst` resets the external ramp, and the sweep begins. `req_ready` is low for the whole sweep. A request presented while `req_ready` is low is not queued and has no effect. The requester does not need to hold it, and it is simply dropped. The shared count runs in Gray code and passes through one pipeline register. Every channel compares against that same register, so all channels have the same latency.

`busy` is high from the cycle after acceptance until the sweep has drained. A one-cycle `done` pulse marks the end of the sweep, and in that same cycle `busy` falls and `req_ready` rises again.

Top module: `ramp_dac_seq`

## Requirements
- R1: After reset `req_ready`=1, `busy`=0, `done`=0, `ramp_rst`=0 and `sample_stb`=0. At all times `req_ready` is the inverse of `busy`.
- R2: In the cycle after an accepted request (cycle 0), `ramp_rst` is high for exactly one cycle. It is not high in any other cycle of the sweep.
- R3: `busy` is high for exactly 4097 consecutive cycles (cycles 0 to 4096) after acceptance. It is low in cycle 4097 and in the cycles after it.
- R4: `done` is high for exactly one cycle per sweep, in cycle 4097.
- R5: Channel i takes its code from `req_codes[12*i+11:12*i]`. Its strobe `sample_stb[i]` is high for exactly one cycle per sweep, in cycle code+2.
- R6: Code 0 strobes in cycle 2, and code 4095 strobes in cycle 4097, which is the same cycle as `done`.
- R7: A request presented while `busy` is high is ignored. It causes no `ramp_rst`, and the strobe timing still follows the codes accepted at the start of the sweep.
- R8: Codes are captured only at acceptance. Changes on `req_codes` later in the sweep do not move any strobe.
- R9: Channels holding equal codes strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_codes | input | 36 | Three 12-bit codes, channel 0 in the low bits |
| ramp_rst | output | 1 | One-cycle reset pulse to the ramp generator |
| sample_stb | output | 3 | Per-channel track-and-hold sample strobe |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
All result times count from the cycle after the accepting edge, which is cycle 0. `ramp_rst` is due in cycle 0 and `busy` rises in cycle 0. The strobe for code c is due in cycle c+2, because it passes through the binary counter, the Gray pipeline stage and the strobe register. `done` is due in cycle 4097, and `busy` falls in that same cycle. The bench samples every output on the falling edge of each of cycles 0 to 4101 after acceptance and records the cycle of each event. It then compares those cycles with the values its own functions derive from the codes that were accepted. Late requests and code changes are injected in the middle of some sweeps, so that any leakage would show up as a moved or extra pulse.

// File: rtl/ramp_dac_pkg.sv
package ramp_dac_pkg;
  localparam int unsigned RDS_CODE_W = 12;
  localparam int unsigned RDS_NUM_CH = 3;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SWEEP = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rds_gray_cnt.sv
module rds_gray_cnt #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [CODE_W-1:0] gray_q,
  output logic              gray_vld,
  output logic              gray_last
);
  localparam logic [CODE_W-1:0] CNT_MAX = {CODE_W{1'b1}};

  function automatic logic [CODE_W-1:0] to_gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [CODE_W-1:0] bin_q;
  logic              run_q;

  // stage 0: binary count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      bin_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      bin_q <= bin_q + 1'b1;
      if (bin_q == CNT_MAX) run_q <= 1'b0;
    end
  end

  // stage 1: Gray-coded count shared by all comparators
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q    <= '0;
      gray_vld  <= 1'b0;
      gray_last <= 1'b0;
    end else begin
      gray_q    <= to_gray(bin_q);
      gray_vld  <= run_q;
      gray_last <= run_q && (bin_q == CNT_MAX);
    end
  end

  AST_GRAY_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (gray_vld && $past(gray_vld)) |-> ($countones(gray_q ^ $past(gray_q)) == 1)); // R5
  AST_LAST_ENDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    gray_last |=> !gray_vld); // R3
endmodule

// File: rtl/rds_chan.sv
module rds_chan #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CODE_W-1:0] gray_q,
  input  logic              gray_vld,
  output logic              strobe
);
  function automatic logic [CODE_W-1:0] to_gray(input logic [CODE_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [CODE_W-1:0] code_g_q;
  logic              fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_g_q <= '0;
    else if (start) code_g_q <= to_gray(code_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else strobe <= gray_vld && (gray_q == code_g_q);
  end

  // tracks whether this sweep has already strobed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else if (start) fired_q <= 1'b0;
    else if (strobe) fired_q <= 1'b1;
  end

  AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R5
  AST_STROBE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !fired_q); // R5
endmodule

// File: rtl/rds_ctrl.sv
module rds_ctrl
  import ramp_dac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic start,
  input  logic gray_last,
  output logic ramp_rst,
  output logic busy,
  output logic done
);
  seq_state_e state_q;

  assign busy      = (state_q == SEQ_SWEEP);
  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      ramp_rst <= 1'b0;
      done     <= 1'b0;
    end else begin
      ramp_rst <= start;
      done     <= gray_last;
      unique case (state_q)
        SEQ_IDLE:  if (start) state_q <= SEQ_SWEEP;
        SEQ_SWEEP: if (gray_last) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_RAMP_RST_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst |=> !ramp_rst); // R2
  AST_DONE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !ramp_rst); // R7
  AST_RAMP_RST_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_rst |-> (busy && !$past(busy))); // R2
endmodule

// File: rtl/ramp_dac_seq.sv
module ramp_dac_seq #(
  parameter int unsigned CODE_W = ramp_dac_pkg::RDS_CODE_W,
  parameter int unsigned NUM_CH = ramp_dac_pkg::RDS_NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [NUM_CH*CODE_W-1:0] req_codes,
  output logic                     ramp_rst,
  output logic [NUM_CH-1:0]        sample_stb,
  output logic                     busy,
  output logic                     done
);
  logic              start;
  logic [CODE_W-1:0] gray_q;
  logic              gray_vld;
  logic              gray_last;

  rds_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .start     (start),
    .gray_last (gray_last),
    .ramp_rst  (ramp_rst),
    .busy      (busy),
    .done      (done)
  );

  rds_gray_cnt #(.CODE_W(CODE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .gray_q    (gray_q),
    .gray_vld  (gray_vld),
    .gray_last (gray_last)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    rds_chan #(.CODE_W(CODE_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .code_in  (req_codes[ch*CODE_W +: CODE_W]),
      .gray_q   (gray_q),
      .gray_vld (gray_vld),
      .strobe   (sample_stb[ch])
    );
  end

  AST_READY_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy); // R1
endmodule

// File: tb/ramp_dac_seq_tb_top.sv
module ramp_dac_seq_tb_top;
  localparam int W = 12;
  localparam int NCH = 3;
  localparam int SWEEP_CYC = 4102;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [NCH*W-1:0] req_codes = '0;
  logic ramp_rst;
  logic [NCH-1:0] sample_stb;
  logic busy;
  logic done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ramp_dac_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_codes(req_codes), .ramp_rst(ramp_rst), .sample_stb(sample_stb),
    .busy(busy), .done(done)
  );

  function automatic int exp_stb_cycle(input int code);
    return code + 2;
  endfunction
  function automatic int exp_done_cycle();
    return 4097;
  endfunction
  function automatic int exp_busy_cycles();
    return 4097;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_sweep(input logic [W-1:0] c0, input logic [W-1:0] c1,
                           input logic [W-1:0] c2, input bit intrude);
    int stb_cnt [NCH];
    int stb_at [NCH];
    int ramp_cnt, ramp_at, done_cnt, done_at, busy_cnt, busy_last;
    logic [W-1:0] codes [NCH];
    codes[0] = c0; codes[1] = c1; codes[2] = c2;
    for (int i = 0; i < NCH; i++) begin stb_cnt[i] = 0; stb_at[i] = -1; end
    ramp_cnt = 0; ramp_at = -1; done_cnt = 0; done_at = -1; busy_cnt = 0; busy_last = -1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", int'(req_ready), 1);
    req_codes = {c2, c1, c0};
    req_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < SWEEP_CYC; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (ramp_rst) begin ramp_cnt++; ramp_at = k; end
      if (done) begin done_cnt++; done_at = k; end
      if (busy) begin busy_cnt++; busy_last = k; end
      for (int i = 0; i < NCH; i++)
        if (sample_stb[i]) begin stb_cnt[i]++; stb_at[i] = k; end
      if (k == 20) req_codes = {$urandom(), $urandom()}; // R8 late change, no valid
      if (intrude) begin
        if (k == 50) begin req_valid = 1'b1; req_codes = {$urandom(), $urandom()}; end
        if (k == 55) chk(req_ready == 1'b0, "R1 ready low while busy", int'(req_ready), 0);
        if (k == 60) req_valid = 1'b0;
      end
    end
    chk(ramp_cnt == 1 && ramp_at == 0, "R2 ramp_rst cycle", ramp_at, 0);
    chk(busy_cnt == exp_busy_cycles() && busy_last == 4096, "R3 busy cycles",
        busy_cnt, exp_busy_cycles());
    chk(done_cnt == 1 && done_at == exp_done_cycle(), "R4 done cycle", done_at, exp_done_cycle());
    for (int i = 0; i < NCH; i++) begin
      chk(stb_cnt[i] == 1, "R5 strobe count", stb_cnt[i], 1);
      chk(stb_at[i] == exp_stb_cycle(int'(codes[i])),
          intrude ? "R7 R8 strobe cycle" : "R5 R6 R8 strobe cycle",
          stb_at[i], exp_stb_cycle(int'(codes[i])));
    end
    if (c0 == c1) chk(stb_at[0] == stb_at[1], "R9 equal codes align", stb_at[1], stb_at[0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && busy == 1'b0, "R1 reset ready/busy", int'(busy), 0);
    chk(done == 1'b0 && ramp_rst == 1'b0, "R1 reset done/ramp", int'(done), 0);
    chk(sample_stb == '0, "R1 reset strobes", int'(sample_stb), 0);

    run_sweep(12'd0, 12'd4095, 12'd2048, 1'b0);   // R6 extremes
    run_sweep(12'd5, 12'd5, 12'd5, 1'b0);         // R9 equal codes
    run_sweep(12'd4095, 12'd0, 12'd1, 1'b1);      // R7 intrusion
    run_sweep(12'd1, 12'd1, 12'd4094, 1'b0);
    for (int n = 0; n < 7; n++)
      run_sweep(W'($urandom()), W'($urandom()), W'($urandom()), n[0]);

    repeat (10) begin
      @(negedge clk);
      chk(sample_stb == '0 && !busy, "R1 idle quiet", int'(sample_stb), 0);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule